// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block recovers one byte at a time from an asynchronous serial line. A frame on the line is a single low start bit, eight data bits sent least significant first, and a single high stop bit; between frames the line rests high. The block is clocked at eight times the bit rate. A single sample counter, running only while a frame is being received, times everything: its low bits pick the sample point near the centre of every bit, and one decoded count marks the end of the frame.

The line first passes through a chain of synchronizing flops. When the synchronized line drops, the sample counter starts. A two-state frame controller has the states FR_IDLE and FR_RECV. The transition "latch" (FR_IDLE to FR_RECV) fires when the counter reaches the mid-bit phase of the start bit while still running. From then on the counter keeps running whatever the line does. The transition "complete" (FR_RECV to FR_IDLE) fires at the decoded end count. Reset forces FR_IDLE from either state. A shift register takes nine mid-bit samples, so the start bit falls out of the bottom and the eight data bits are left in place. The stop bit is never sampled. At the end count the byte is copied to a held output register, and a one-cycle ready strobe is raised.

Top module: `os_uart_rx`

## Requirements
- R1: After a synchronous reset, `rdy_o` is 0, `byte_o` is 0, the sample counter is 0 and the controller is in FR_IDLE.
- R2: For a frame made of a low start bit, then data bits D0..D7 (D0 first), then a high stop bit, each bit lasting 8 clocks, `byte_o` equals the data with D0 in bit 0 and D7 in bit 7.
- R3: `rx_i` is used only after two flops of synchronization. The first rising edge at which `rx_i` is seen low counts as edge 1 of a frame.
- R4: A low pulse on `rx_i` of 4 clocks or fewer, with the line high on both sides, produces no `rdy_o` and leaves `byte_o` unchanged. A frame that follows it is received correctly.
- R5: A bit is sampled only when the low three bits of the sample counter equal 3'b100. Nine samples are taken (counts 4, 12, ..., 68), and the first one, the start bit, is shifted out.
- R6: `rdy_o` is high for exactly one clock per frame. It rises at edge 78 counted from edge 1 of R3, which is one clock after the counter reaches 75.
- R7: At count 75 the counter returns to 0 and the controller returns to FR_IDLE. A new start bit that begins right after the 8-clock stop bit is received normally (back-to-back frames).
- R8: `byte_o` changes only together with a `rdy_o` pulse, and holds its value until the next one.
- R9: A reset in the middle of a frame abandons that frame: no `rdy_o` follows for it.
- R10: The sample counter never exceeds 75.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, eight times the bit rate |
| rst_i | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Asynchronous serial line, idles high |
| byte_o | output | DATA_W (8) | Last byte received, held between strobes |
| rdy_o | output | 1 | One-clock strobe when `byte_o` has just been loaded |

## Verification
The bench drives all-zero and all-one bytes. In an all-zero byte the line stays low for nine bits, so a design that sampled off-centre or let the start bit stay in the register would return a shifted value. It sends back-to-back frames with no idle gap, which a counter that is not cleared at the end count would merge or drop. It also sends a short low glitch, which a controller that latches without checking that the counter still runs would turn into a phantom byte. Last, it resets the block mid-frame, which must leave no strobe behind. Every clock, the bench compares the strobe timing (edge 78) and the held byte against a queue of expected events.

// File: rtl/rx_pkg.sv
package rx_pkg;

    // Frame controller states
    typedef enum logic [0:0] {
        FR_IDLE = 1'b0,
        FR_RECV = 1'b1
    } frame_st_e;

    // Count at which a frame ends: start plus data bits fully elapsed,
    // then half of the stop bit minus one sample.
    function automatic int end_count(input int osr, input int data_w);
        return (data_w + 1) * osr + osr / 2 - 1;
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d_i;
            for (int k = 1; k < STAGES; k++) begin
                chain[k] <= chain[k-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/rx_seq.sv
module rx_seq
    import rx_pkg::*;
#(
    parameter int OSR    = 8,
    parameter int DATA_W = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic line_i,
    output logic shift_o,
    output logic done_o
);

    localparam int PHASE_W = $clog2(OSR);
    localparam int END_N   = end_count(OSR, DATA_W);
    localparam int CNT_W   = $clog2(END_N + 1);
    localparam logic [PHASE_W-1:0] MID_PH = PHASE_W'(OSR / 2);
    localparam logic [CNT_W-1:0]   END_C  = CNT_W'(END_N);

    frame_st_e         state_q;
    frame_st_e         state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              run;
    logic              at_end;

    // Counter runs while the line is low or a frame has been latched
    assign run    = !line_i || (state_q == FR_RECV);
    assign at_end = (cnt_q == END_C);

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= FR_IDLE;
        else       state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE: if (run && cnt_q[PHASE_W-1] && !at_end) state_d = FR_RECV; // latch
            FR_RECV: if (at_end)                            state_d = FR_IDLE; // complete
        endcase
    end

    // Sample counter: cleared when stopped, at the end count, or on reset
    always_ff @(posedge clk_i) begin
        if (rst_i || !run || at_end) cnt_q <= '0;
        else                         cnt_q <= cnt_q + CNT_W'(1);
    end

    // Outputs
    always_comb begin
        shift_o = run && (cnt_q[PHASE_W-1:0] == MID_PH);
        done_o  = at_end;
    end

    // R10: counter bounded by the end count
    p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= END_C);

    // R7: the end count clears the counter and releases the frame
    p_end_clears_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> (cnt_q == '0 && state_q == FR_IDLE));

    // R4: with the line high and no frame latched, the counter sits at zero
    p_idle_rest_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == FR_IDLE && line_i) |=> (cnt_q == '0));

    // R5: a frame is latched exactly at the mid-bit phase of the start bit
    p_latch_mid_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(state_q == FR_RECV) |-> (cnt_q == CNT_W'(OSR / 2 + 1)));

endmodule

// File: rtl/rx_shreg.sv
module rx_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              shift_i,
    input  logic              bit_i,
    input  logic              load_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              rdy_o
);

    logic [DATA_W-1:0] sr_q;

    // Samples enter at the top and move toward bit 0
    always_ff @(posedge clk_i) begin
        if (rst_i)        sr_q <= '0;
        else if (shift_i) sr_q <= {bit_i, sr_q[DATA_W-1:1]};
    end

    // Held output and strobe
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            byte_o <= '0;
            rdy_o  <= 1'b0;
        end else begin
            rdy_o <= load_i;
            if (load_i) byte_o <= sr_q;
        end
    end

    // R6: strobe lasts one clock
    p_rdy_pulse_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        rdy_o |=> !rdy_o);

    // R8: the held byte moves only with the strobe
    p_byte_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !rdy_o |-> $stable(byte_o));

endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx #(
    parameter int OSR         = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rx_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              rdy_o
);

    generate
        if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
            $error("OSR must be a power of two, at least 4");
        end
        if (SYNC_STAGES < 1) begin : g_bad_sync
            $error("SYNC_STAGES must be at least 1");
        end
    endgenerate

    logic line;
    logic shift;
    logic done;

    rx_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .d_i  (rx_i),
        .q_o  (line)
    );

    rx_seq #(
        .OSR   (OSR),
        .DATA_W(DATA_W)
    ) u_seq (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .line_i (line),
        .shift_o(shift),
        .done_o (done)
    );

    rx_shreg #(
        .DATA_W(DATA_W)
    ) u_shreg (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .shift_i(shift),
        .bit_i  (line),
        .load_i (done),
        .byte_o (byte_o),
        .rdy_o  (rdy_o)
    );

    // R6: a strobe needs the end count on the previous clock
    p_rdy_after_end_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        done |=> rdy_o);

endmodule

// File: tb/sim_os_uart_rx.sv
`timescale 1ns/1ps
module sim_os_uart_rx;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx;
    logic [7:0] byte_o;
    logic       rdy_o;

    always #2 clk = ~clk;   // 250 MHz

    os_uart_rx u0 (
        .clk_i (clk),
        .rst_i (rst),
        .rx_i  (rx),
        .byte_o(byte_o),
        .rdy_o (rdy_o)
    );

    int         cyc = 0;
    int         n_cmp = 0;
    int         n_bad = 0;
    int         n_sent = 0;
    int         n_seen = 0;
    bit         chk_en = 1'b0;
    string      tag = "R1";
    int         q_t[$];
    logic [7:0] q_b[$];
    logic [7:0] held = 8'h00;

    always @(posedge clk) cyc <= cyc + 1;

    // Per-clock reference comparison: strobe at edge 78 (R3, R6), byte (R2),
    // held value otherwise (R8)
    always @(negedge clk) begin
        if (chk_en) begin
            logic       e_rdy;
            logic [7:0] e_b;
            if (q_t.size() > 0 && q_t[0] == cyc) begin
                e_rdy = 1'b1;
                e_b   = q_b[0];
            end else begin
                e_rdy = 1'b0;
                e_b   = held;
            end
            n_cmp++;
            if (rdy_o !== e_rdy || byte_o !== e_b) begin
                n_bad++;
                $display("FAIL %s (R6 strobe/R8 hold) cyc=%0d: rdy=%b byte=%h, expected rdy=%b byte=%h",
                         tag, cyc, rdy_o, byte_o, e_rdy, e_b);
            end
            if (rdy_o === 1'b1) n_seen++;
            if (e_rdy) begin
                held = e_b;
                void'(q_t.pop_front());
                void'(q_b.pop_front());
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h, expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge; holds the line for one bit time
    task automatic hold_bit(input logic v);
        rx = v;
        repeat (8) @(negedge clk);
    endtask

    // R2/R5: start low, D0 first, stop high
    task automatic send_frame(input logic [7:0] b);
        q_t.push_back(cyc + 78);
        q_b.push_back(b);
        n_sent++;
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(b[i]);
        hold_bit(1'b1);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rx  = 1'b1;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(rdy_o === 1'b0, "R1 rdy after reset", int'(rdy_o), 0);
        check(byte_o === 8'h00, "R1 byte after reset", int'(byte_o), 0);
        chk_en = 1'b1;
        repeat (4) @(negedge clk);

        // R5: extreme and single-bit patterns, centre sampling and start discard
        tag = "R5";
        send_frame(8'h00);
        repeat (3) @(negedge clk);
        send_frame(8'hFF);
        repeat (5) @(negedge clk);
        send_frame(8'h01);
        repeat (2) @(negedge clk);
        send_frame(8'h80);
        repeat (6) @(negedge clk);

        // R2: random bytes with random start phase
        tag = "R2";
        for (int n = 0; n < 30; n++) begin
            send_frame(8'($urandom_range(0, 255)));
            repeat (int'($urandom_range(0, 12))) @(negedge clk);
        end

        // R7: back-to-back frames, no idle gap
        tag = "R7";
        for (int n = 0; n < 5; n++) send_frame(8'($urandom_range(0, 255)));
        repeat (10) @(negedge clk);

        // R4: short low glitch must be ignored, then a normal frame
        tag = "R4";
        rx = 1'b0;
        repeat (3) @(negedge clk);
        rx = 1'b1;
        repeat (40) @(negedge clk);
        rx = 1'b0;
        repeat (4) @(negedge clk);
        rx = 1'b1;
        repeat (40) @(negedge clk);
        send_frame(8'hA5);
        repeat (10) @(negedge clk);

        // R9: reset mid-frame abandons the frame
        tag = "R9";
        rx = 1'b0;
        repeat (8) @(negedge clk);
        rx = 1'b1;
        repeat (16) @(negedge clk);
        chk_en = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        held = 8'h00;
        @(negedge clk);
        check(rdy_o === 1'b0, "R9 no strobe after abort", int'(rdy_o), 0);
        chk_en = 1'b1;
        repeat (100) @(negedge clk);
        send_frame(8'h3C);
        repeat (100) @(negedge clk);

        // R6: exactly one strobe per frame, none missing
        check(n_seen == n_sent, "R6 strobe count", n_seen, n_sent);
        check(q_t.size() == 0, "R6 pending frames", q_t.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule